// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit sits in the shifter path of a 32-bit processor. It decodes two immediate-form bit-field instructions and executes them. Extract pulls a field of a given width out of source operand A, starting at a given bit offset, and returns it right-aligned with every bit above it cleared. Insert takes the low bits of source operand A and places them at a given offset in the current destination value. Every destination bit outside the field keeps its old value.

The caller supplies three inputs: the instruction word, the source operand and the current destination value. The unit returns four outputs, all registered once:

- the result,
- a write-enable,
- a match flag,
- an illegal-operand flag.

An instruction word that belongs to neither form leaves the unit silent, so the unit can be placed beside the other execute units and fed every instruction.

Top module: `bitfield_unit`

## Requirements
- R1: `opMatch` is high exactly when (instruction AND 0xFC00C000) equals 0x64004000 (extract) or 0x64008000 (insert). Setting both bit 14 and bit 15 matches neither form.
- R2: Instruction bits 4:0 give the field offset (0..31). Instruction bits 10:6 give the extract width, or the insert field's top bit position. Instruction bits 25:16 have no effect on the result.
- R3: Extract returns the selected field right-aligned, with all result bits at or above the width equal to zero. The destination input has no effect on extract.
- R4: An extract width field of 0 means a width of 32.
- R5: When offset plus width exceeds 32, extract returns only the source bits up to bit 31, and the missing upper bits are zero.
- R6: Insert uses width = top − offset + 1. It writes the low width bits of source A into the destination from the offset upward and keeps every other destination bit.
- R7: For insert, a top position below the offset raises `opIllegal`. In that case `writeEn` is low and the result is zero.
- R8: A word that matches neither form gives a result of zero, with `writeEn` low and `opIllegal` low.
- R9: `writeEn` is high only for a matching instruction with legal operands.
- R10: With `REG_OUT`=1 (the default), outputs show the operation presented one clock earlier. An active-low reset forces all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the output stage |
| instrWord | input | 32 | Instruction word to decode |
| srcA | input | 32 | Source operand A |
| dstOld | input | 32 | Current destination value (used by insert) |
| result | output | 32 | Extract or insert result |
| writeEn | output | 1 | Destination write request |
| opMatch | output | 1 | Instruction is one of the two bit-field forms |
| opIllegal | output | 1 | Insert with top position below offset |

## Verification
The assertions check four properties on every cycle:

- extract never leaves a bit set outside its field mask;
- insert never changes a destination bit outside its placed mask;
- a non-matching word stays quiet;
- the write request never comes with an illegal or unmatched word.

Only the bench scenarios can show the exact field values. These include the width-0-means-32 rule, the fields that run past bit 31, the one-bit and full-width inserts, the one-cycle output latency and the reset clearing.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int BF_DATA_W = 32;
  localparam int BF_POS_W  = $clog2(BF_DATA_W);

  localparam logic [BF_DATA_W-1:0] BF_OP_MASK  = 32'hFC00_C000;
  localparam logic [BF_DATA_W-1:0] BF_PAT_EXT  = 32'h6400_4000;
  localparam logic [BF_DATA_W-1:0] BF_PAT_INS  = 32'h6400_8000;

  localparam int BF_OFS_LSB = 0;
  localparam int BF_HI_LSB  = 6;

  typedef struct packed {
    logic                doExtract;
    logic                doInsert;
    logic                illegal;
    logic [BF_POS_W:0]   width;
    logic [BF_POS_W-1:0] offset;
  } bfCtrl_t;
endpackage

// File: rtl/bf_ctrl.sv
module bf_ctrl
  import bf_pkg::*;
(
  input  logic [BF_DATA_W-1:0] instrWord,
  output bfCtrl_t              ctrl,
  output logic                 opMatch
);
  localparam logic [BF_POS_W:0] FULL_W = (BF_POS_W+1)'(BF_DATA_W);

  logic                isExt;
  logic                isIns;
  logic [BF_POS_W-1:0] ofsField;
  logic [BF_POS_W-1:0] hiField;
  logic [BF_POS_W:0]   extWidth;
  logic [BF_POS_W:0]   insWidth;
  logic                insBad;

  always_comb begin
    isExt    = (instrWord & BF_OP_MASK) == BF_PAT_EXT;
    isIns    = (instrWord & BF_OP_MASK) == BF_PAT_INS;
    ofsField = instrWord[BF_OFS_LSB +: BF_POS_W];
    hiField  = instrWord[BF_HI_LSB  +: BF_POS_W];
    extWidth = (hiField == '0) ? FULL_W : {1'b0, hiField};
    insWidth = {1'b0, hiField} - {1'b0, ofsField} + (BF_POS_W+1)'(1);
    insBad   = isIns && (hiField < ofsField);
  end

  always_comb begin
    ctrl.doExtract = isExt;
    ctrl.doInsert  = isIns && !insBad;
    ctrl.illegal   = insBad;
    ctrl.width     = isExt ? extWidth : (isIns && !insBad) ? insWidth : '0;
    ctrl.offset    = (isExt || isIns) ? ofsField : '0;
    opMatch        = isExt || isIns;
  end
endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
  import bf_pkg::*;
(
  input  bfCtrl_t              ctrl,
  input  logic [BF_DATA_W-1:0] srcA,
  input  logic [BF_DATA_W-1:0] dstOld,
  output logic [BF_DATA_W-1:0] resultComb,
  output logic [BF_DATA_W-1:0] fieldMask,
  output logic                 writeComb
);
  localparam logic [BF_POS_W:0]    FULL_W = (BF_POS_W+1)'(BF_DATA_W);
  localparam logic [BF_DATA_W-1:0] ONE    = BF_DATA_W'(1);

  logic [BF_DATA_W-1:0] lowMask;
  logic [BF_DATA_W-1:0] placedMask;
  logic [BF_DATA_W-1:0] extVal;
  logic [BF_DATA_W-1:0] insVal;

  always_comb begin
    if (ctrl.width >= FULL_W) lowMask = '1;
    else                      lowMask = (ONE << ctrl.width) - ONE;
    placedMask = lowMask << ctrl.offset;
    extVal     = (srcA >> ctrl.offset) & lowMask;
    insVal     = (dstOld & ~placedMask) | ((srcA << ctrl.offset) & placedMask);
  end

  always_comb begin
    resultComb = '0;
    fieldMask  = '0;
    if (ctrl.doExtract) begin
      resultComb = extVal;
      fieldMask  = lowMask;
    end else if (ctrl.doInsert) begin
      resultComb = insVal;
      fieldMask  = placedMask;
    end
    writeComb = ctrl.doExtract || ctrl.doInsert;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bf_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BF_DATA_W-1:0] instrWord,
  input  logic [BF_DATA_W-1:0] srcA,
  input  logic [BF_DATA_W-1:0] dstOld,
  output logic [BF_DATA_W-1:0] result,
  output logic                 writeEn,
  output logic                 opMatch,
  output logic                 opIllegal
);
  bfCtrl_t              ctrl;
  logic                 matchComb;
  logic [BF_DATA_W-1:0] resultComb;
  logic [BF_DATA_W-1:0] fieldMask;
  logic                 writeComb;

  bf_ctrl u_ctrl (
    .instrWord (instrWord),
    .ctrl      (ctrl),
    .opMatch   (matchComb)
  );

  bf_datapath u_dp (
    .ctrl       (ctrl),
    .srcA       (srcA),
    .dstOld     (dstOld),
    .resultComb (resultComb),
    .fieldMask  (fieldMask),
    .writeComb  (writeComb)
  );

  AST_EXTRACT_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doExtract |-> ((resultComb & ~fieldMask) == '0)); // R3
  AST_INSERT_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doInsert |-> (((resultComb ^ dstOld) & ~fieldMask) == '0)); // R6
  AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !matchComb |-> (resultComb == '0 && !writeComb && !ctrl.illegal)); // R8
  AST_WRITE_NEEDS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    writeComb |-> (matchComb && !ctrl.illegal)); // R9

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          result    <= '0;
          writeEn   <= 1'b0;
          opMatch   <= 1'b0;
          opIllegal <= 1'b0;
        end else begin
          result    <= resultComb;
          writeEn   <= writeComb;
          opMatch   <= matchComb;
          opIllegal <= ctrl.illegal;
        end
      end
    end else begin : g_comb
      always_comb begin
        result    = resultComb;
        writeEn   = writeComb;
        opMatch   = matchComb;
        opIllegal = ctrl.illegal;
      end
    end
  endgenerate

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    opIllegal |-> (!writeEn && result == '0)); // R7
  AST_ILLEGAL_IMPLIES_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    opIllegal |-> opMatch); // R1
endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] instrWord, srcA, dstOld;
  logic [31:0] result;
  logic        writeEn, opMatch, opIllegal;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .srcA(srcA), .dstOld(dstOld),
    .result(result), .writeEn(writeEn), .opMatch(opMatch), .opIllegal(opIllegal)
  );

  // {instr, srcA, dstOld, expResult, expMatch, expIllegal, expWrite}
  localparam int NV = 13;
  localparam logic [130:0] VEC [NV] = '{
    {32'h6400_4204, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0067, 3'b101}, // R3 w8 off4
    {32'h6400_4000, 32'hDEAD_BEEF, 32'h1111_1111, 32'hDEAD_BEEF, 3'b101}, // R4 width 0 -> 32
    {32'h6400_4418, 32'hABCD_1234, 32'h0000_0000, 32'h0000_00AB, 3'b101}, // R5 runs past 31
    {32'h6400_405F, 32'h8000_0000, 32'h0000_0000, 32'h0000_0001, 3'b101}, // R3 w1 off31
    {32'h6400_83C8, 32'h0000_00A5, 32'hFFFF_FFFF, 32'hFFFF_A5FF, 3'b101}, // R6 w8 off8
    {32'h6400_87C0, 32'h1357_9BDF, 32'h0000_0000, 32'h1357_9BDF, 3'b101}, // R6 full width
    {32'h6400_8145, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFDF, 3'b101}, // R6 one bit
    {32'h6400_87DC, 32'h0000_0005, 32'h1234_5678, 32'h5234_5678, 3'b101}, // R6 top nibble
    {32'h6400_80CA, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 3'b110}, // R7 top<offset
    {32'h6400_0400, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 3'b000}, // R8 other shift
    {32'h6400_C000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 3'b000}, // R1 both bits
    {32'hA400_4204, 32'h1234_5678, 32'h0000_0000, 32'h0000_0000, 3'b000}, // R1 other opcode
    {32'h67E5_4204, 32'h1234_5678, 32'h0000_0000, 32'h0000_0067, 3'b101}  // R2 reg fields
  };

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s result actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    instrWord = i; srcA = a; dstOld = d;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    instrWord = 32'h6400_4000; srcA = 32'hFFFF_FFFF; dstOld = '0;
    repeat (3) @(negedge clk);
    // R10 reset clears outputs even with a matching word present
    chk32("R10", result, 32'h0);
    chk1("R10", "writeEn", writeEn, 1'b0);
    chk1("R10", "opMatch", opMatch, 1'b0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][130:99], VEC[k][98:67], VEC[k][66:35]);
      chk32($sformatf("R9 vec%0d", k), result, VEC[k][34:3]);
      chk1($sformatf("R1 vec%0d", k), "opMatch", opMatch, VEC[k][2]);
      chk1($sformatf("R7 vec%0d", k), "opIllegal", opIllegal, VEC[k][1]);
      chk1($sformatf("R9 vec%0d", k), "writeEn", writeEn, VEC[k][0]);
    end

    // R3 destination has no effect on extract
    apply(32'h6400_4204, 32'h1234_5678, 32'hA5A5_A5A5);
    chk32("R3", result, 32'h0000_0067);

    // R10 one-cycle latency: result holds old value until the next edge
    @(negedge clk);
    instrWord = 32'h6400_87C0; srcA = 32'hCAFE_F00D; dstOld = '0;
    @(posedge clk); #1;
    chk32("R10", result, 32'hCAFE_F00D);
    instrWord = 32'h6400_0000;
    @(negedge clk);
    chk32("R10", result, 32'hCAFE_F00D);
    @(negedge clk);
    chk1("R10", "writeEn", writeEn, 1'b0);

    // R2 offset field: extract width 4 at offset 12
    apply(32'h6400_410C, 32'h0000_B000, 32'h0);
    chk32("R2", result, 32'h0000_000B);

    // R10 mid-run reset clears a live result
    apply(32'h6400_4000, 32'hFFFF_FFFF, 32'h0);
    rstN = 1'b0;
    @(negedge clk);
    chk32("R10", result, 32'h0);
    chk1("R10", "writeEn", writeEn, 1'b0);
    rstN = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule